// File: doc/BRIEF.md
# TPM-over-SPI Transaction Engine

This block is the device-side engine for TPM register transactions carried over an SPI target link. It runs in the SPI clock domain and is framed by an active-low chip select. Each byte slot is marked by `byte_vld_i`. The engine decodes a command byte and a three-byte address. It then decides whether a read can be answered at once from locally held copies of the hardware-returned registers. Any other transaction is handed to software through a single-entry command/address mailbox.

Flow control uses WAIT and START bytes. The engine keeps returning WAIT until the read response is ready, or until the write FIFO has drained. It then returns START and moves the payload. A read response is popped from the read FIFO one byte per slot. Write payload bytes are pushed into the write FIFO. A level-sensitive interrupt follows the occupancy of the mailbox. The FIFO storage, the register bus and the clock-domain crossings live outside this block.

Top module: `tpm_spi_engine`

## Requirements
- R1: While `cfg_en_i` is 0, a transaction has no effect. Every reply byte is 0xFF, no mailbox entry appears, and neither FIFO is pushed or popped.
- R2: The command byte carries the direction in bit 7 (1 = read) and the length minus one in bits 5:0. Three address bytes follow, most significant first. A posted entry reads `{cmd, addr[23:0]}` on `mb_data_o`, with the command in bits 31:24.
- R3: The reply byte during the last address byte is WAIT (0x00). Each following flow byte is either WAIT (0x00) or START (0x01), and data bytes begin in the slot right after START. Outside a transaction, in the command slot and in the first two address slots, the reply is 0xFF.
- R4: A read is handled locally when all of the following hold: mode 0 (`cfg_crb_i` = 0), `cfg_hwdis_i` = 0, address bits 23:16 equal to 0xD4, and offset bits 11:2 matching 0x000 (access), 0x018 (status) or 0xF00 (identifier). A locally handled read answers START on the first flow byte, so it has exactly one WAIT, and it posts no mailbox entry. Data bytes are the little-endian bytes of the 32-bit register, starting at byte `addr[1:0]` and wrapping inside the word.
- R5: Locality is `addr[15:12]`. The access register returns that locality's access byte, zero-extended. The status register returns `sts_i` only when bit 5 of that locality's access byte is set, and otherwise returns 0xFF bytes.
- R6: A locality of `NUM_LOC` or above is invalid. A hardware-register read with an invalid locality returns 0xFF bytes locally when `cfg_invloc_i` = 0, and takes the software path when `cfg_invloc_i` = 1.
- R7: In mode 1, and whenever `cfg_hwdis_i` = 1, every read is posted to the mailbox. The engine then replies WAIT until `rd_ready_i` is 1 after posting, and START after that. Each data byte is taken from `rd_data_i` and pops the read FIFO once.
- R8: A write is posted to the mailbox. The engine replies WAIT while `wr_empty_i` is 0, and START once it is 1 after posting. Each payload byte is then pushed to the write FIFO unchanged.
- R9: The mailbox holds one entry. A transaction that needs to post while it is full keeps replying WAIT and leaves the held entry unchanged. `irq_o` stays 1 until the entry is popped.
- R10: Raising `cs_ni` at any point aborts the transaction. The next transaction is decoded from its own command byte.
- R11: The access, status and identifier inputs are captured only while `cs_ni` is 1, so a change during a transaction does not alter that transaction's reply.
- R12: After length bytes of data, further bytes return 0xFF and neither pop nor push a FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | SPI-domain clock |
| rst_ni | input | 1 | Active-low reset |
| cs_ni | input | 1 | Active-low chip select framing a transaction |
| byte_vld_i | input | 1 | One byte slot completes in this cycle |
| rx_byte_i | input | 8 | Byte received from the host in this slot |
| tx_byte_o | output | 8 | Byte returned to the host in this slot |
| cfg_en_i | input | 1 | Enables the engine |
| cfg_crb_i | input | 1 | Interface style: 0 local register replies allowed, 1 all via software |
| cfg_hwdis_i | input | 1 | Disables local register replies |
| cfg_invloc_i | input | 1 | Routes invalid-locality register reads to software |
| acc_i | input | NUM_LOC*8 | Access byte per locality, locality n at bits 8n+7:8n |
| sts_i | input | 32 | Status register value |
| id_i | input | 32 | Identifier register value |
| mb_valid_o | output | 1 | Mailbox holds an entry |
| mb_data_o | output | 32 | Mailbox entry: command and address |
| mb_pop_i | input | 1 | Software consumes the mailbox entry |
| irq_o | output | 1 | Level interrupt: mailbox not empty |
| rd_ready_i | input | 1 | Read FIFO holds the response |
| rd_data_i | input | 8 | Head byte of the read FIFO |
| rd_pop_o | output | 1 | Consume one read FIFO byte |
| wr_empty_i | input | 1 | Write FIFO is empty |
| wr_push_o | output | 1 | Store one byte into the write FIFO |
| wr_data_o | output | 8 | Byte for the write FIFO |

## Verification
Most internal faults appear in the reply stream of the same transaction. A wrong route decision shows up in the first flow byte after the address: START arrives where WAIT was expected, or the reverse, and a mailbox entry appears or goes missing. A wrong byte counter or index shows up within the data slots as a shifted register byte, a missing or extra FIFO pop or push, or a non-0xFF byte after the last data byte. A stale mailbox or shadow state persists past chip-select deassertion, so it appears in the next transaction or as an interrupt that does not fall when the entry is popped.

// File: rtl/tpmx_pkg.sv
package tpmx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_FLOW,
      ST_DATA,
      ST_DONE
   } tpmx_st_e;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_ACC,
      SEL_STS,
      SEL_ID
   } tpmx_sel_e;

   localparam logic [7:0] BYTE_WAIT  = 8'h00;
   localparam logic [7:0] BYTE_START = 8'h01;
   localparam logic [7:0] BYTE_IDLE  = 8'hFF;

endpackage

// File: rtl/tpmx_decode.sv
module tpmx_decode
   import tpmx_pkg::*;
#(
   parameter int          NUM_LOC = 5,
   parameter logic [7:0]  BASE_HI = 8'hD4,
   parameter logic [11:0] OFF_ACC = 12'h000,
   parameter logic [11:0] OFF_STS = 12'h018,
   parameter logic [11:0] OFF_ID  = 12'hF00
) (
   input  logic       rd_i,
   input  logic [7:0] hi_i,
   input  logic [3:0] loc_i,
   input  logic [9:0] word_i,
   input  logic       crb_i,
   input  logic       hwdis_i,
   input  logic       invloc_i,
   output tpmx_sel_e  sel_o,
   output logic       hw_o
);

   localparam logic [4:0] LOC_LIMIT = 5'(NUM_LOC);

   logic loc_bad;

   always_comb begin
      sel_o = SEL_NONE;
      if (hi_i == BASE_HI) begin
         if (word_i == OFF_ACC[11:2])      sel_o = SEL_ACC;
         else if (word_i == OFF_STS[11:2]) sel_o = SEL_STS;
         else if (word_i == OFF_ID[11:2])  sel_o = SEL_ID;
      end
   end

   assign loc_bad = ({1'b0, loc_i} >= LOC_LIMIT);
   assign hw_o    = rd_i && (sel_o != SEL_NONE) && !crb_i && !hwdis_i
                    && !(loc_bad && invloc_i);

endmodule

// File: rtl/tpmx_hwregs.sv
module tpmx_hwregs
   import tpmx_pkg::*;
#(
   parameter int NUM_LOC = 5,
   parameter int ACT_BIT = 5
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 sample_i,
   input  logic [NUM_LOC*8-1:0] acc_i,
   input  logic [31:0]          sts_i,
   input  logic [31:0]          id_i,
   input  logic [3:0]           loc_i,
   input  tpmx_sel_e            sel_i,
   input  logic [1:0]           idx_i,
   output logic [7:0]           byte_o
);

   localparam logic [4:0] LOC_LIMIT = 5'(NUM_LOC);

   logic [NUM_LOC*8-1:0] acc_q;
   logic [31:0]          sts_q, id_q;
   logic [NUM_LOC-1:0]   hit;
   logic [7:0]           acc_cur;
   logic [31:0]          word;
   logic                 loc_ok;

   // shadow copies, refreshed only between transactions
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
         sts_q <= '0;
         id_q  <= '0;
      end else if (sample_i) begin
         acc_q <= acc_i;
         sts_q <= sts_i;
         id_q  <= id_i;
      end
   end

   for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
      assign hit[g] = (loc_i == 4'(g));
   end

   always_comb begin
      acc_cur = '0;
      for (int i = 0; i < NUM_LOC; i++) begin
         acc_cur = acc_cur | (acc_q[8*i +: 8] & {8{hit[i]}});
      end
   end

   assign loc_ok = ({1'b0, loc_i} < LOC_LIMIT);

   always_comb begin
      word = '1;
      if (loc_ok) begin
         case (sel_i)
            SEL_ACC: word = {24'h0, acc_cur};
            SEL_STS: word = acc_cur[ACT_BIT] ? sts_q : '1;
            SEL_ID:  word = id_q;
            default: word = '1;
         endcase
      end
   end

   assign byte_o = word[{idx_i, 3'b000} +: 8];

endmodule

// File: rtl/tpmx_mbox.sv
module tpmx_mbox #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         push_i,
   input  logic [W-1:0] data_i,
   input  logic         pop_i,
   output logic         valid_o,
   output logic [W-1:0] data_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else if (push_i && !valid_o) begin
         valid_o <= 1'b1;
         data_o  <= data_i;
      end else if (pop_i) begin
         valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/tpm_spi_engine.sv
module tpm_spi_engine
   import tpmx_pkg::*;
#(
   parameter int          NUM_LOC = 5,
   parameter int          LEN_W   = 6,
   parameter int          ACT_BIT = 5,
   parameter logic [7:0]  BASE_HI = 8'hD4,
   parameter logic [11:0] OFF_ACC = 12'h000,
   parameter logic [11:0] OFF_STS = 12'h018,
   parameter logic [11:0] OFF_ID  = 12'hF00
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cs_ni,
   input  logic                 byte_vld_i,
   input  logic [7:0]           rx_byte_i,
   output logic [7:0]           tx_byte_o,
   input  logic                 cfg_en_i,
   input  logic                 cfg_crb_i,
   input  logic                 cfg_hwdis_i,
   input  logic                 cfg_invloc_i,
   input  logic [NUM_LOC*8-1:0] acc_i,
   input  logic [31:0]          sts_i,
   input  logic [31:0]          id_i,
   output logic                 mb_valid_o,
   output logic [31:0]          mb_data_o,
   input  logic                 mb_pop_i,
   output logic                 irq_o,
   input  logic                 rd_ready_i,
   input  logic [7:0]           rd_data_i,
   output logic                 rd_pop_o,
   input  logic                 wr_empty_i,
   output logic                 wr_push_o,
   output logic [7:0]           wr_data_o
);

   localparam int         ADDR_W     = 24;
   localparam int         ADDR_BYTES = ADDR_W / 8;
   localparam int         MB_W       = 8 + ADDR_W;
   localparam logic [1:0] ACNT_LAST  = 2'(ADDR_BYTES - 1);

   if (NUM_LOC < 1 || NUM_LOC > 16) begin : g_bad_loc
      $error("NUM_LOC must lie in 1..16");
   end
   if (LEN_W < 2 || LEN_W > 6) begin : g_bad_len
      $error("LEN_W must lie in 2..6");
   end
   if (ACT_BIT < 0 || ACT_BIT > 7) begin : g_bad_act
      $error("ACT_BIT must address a bit of a byte");
   end

   tpmx_st_e          st_q;
   logic [1:0]        acnt_q;
   logic [7:0]        cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  dcnt_q;
   logic              posted_q, hw_q;

   logic       is_rd, hw_route, go, mb_push;
   tpmx_sel_e  sel;
   logic [7:0] hw_byte;
   logic [1:0] idx;

   assign is_rd = cmd_q[7];
   assign idx   = addr_q[1:0] + dcnt_q[1:0];

   tpmx_decode #(
      .NUM_LOC (NUM_LOC),
      .BASE_HI (BASE_HI),
      .OFF_ACC (OFF_ACC),
      .OFF_STS (OFF_STS),
      .OFF_ID  (OFF_ID)
   ) u_decode (
      .rd_i     (is_rd),
      .hi_i     (addr_q[23:16]),
      .loc_i    (addr_q[15:12]),
      .word_i   (addr_q[11:2]),
      .crb_i    (cfg_crb_i),
      .hwdis_i  (cfg_hwdis_i),
      .invloc_i (cfg_invloc_i),
      .sel_o    (sel),
      .hw_o     (hw_route)
   );

   tpmx_hwregs #(
      .NUM_LOC (NUM_LOC),
      .ACT_BIT (ACT_BIT)
   ) u_hwregs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (cs_ni),
      .acc_i    (acc_i),
      .sts_i    (sts_i),
      .id_i     (id_i),
      .loc_i    (addr_q[15:12]),
      .sel_i    (sel),
      .idx_i    (idx),
      .byte_o   (hw_byte)
   );

   tpmx_mbox #(
      .W (MB_W)
   ) u_mbox (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (mb_push),
      .data_i  ({cmd_q, addr_q}),
      .pop_i   (mb_pop_i),
      .valid_o (mb_valid_o),
      .data_o  (mb_data_o)
   );

   assign irq_o = mb_valid_o;

   assign mb_push = (st_q == ST_FLOW) && !cs_ni && !hw_route && !posted_q && !mb_valid_o;
   assign go      = hw_route || (posted_q && (is_rd ? rd_ready_i : wr_empty_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         acnt_q   <= '0;
         cmd_q    <= '0;
         addr_q   <= '0;
         dcnt_q   <= '0;
         posted_q <= 1'b0;
         hw_q     <= 1'b0;
      end else if (cs_ni) begin
         st_q     <= ST_IDLE;
         acnt_q   <= '0;
         posted_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (byte_vld_i && cfg_en_i) begin
               cmd_q  <= rx_byte_i;
               acnt_q <= '0;
               st_q   <= ST_ADDR;
            end
            ST_ADDR: if (byte_vld_i) begin
               addr_q <= {addr_q[ADDR_W-9:0], rx_byte_i};
               acnt_q <= acnt_q + 2'd1;
               if (acnt_q == ACNT_LAST) begin
                  st_q     <= ST_FLOW;
                  posted_q <= 1'b0;
               end
            end
            ST_FLOW: begin
               if (mb_push) posted_q <= 1'b1;
               if (byte_vld_i && go) begin
                  st_q   <= ST_DATA;
                  dcnt_q <= '0;
                  hw_q   <= hw_route;
               end
            end
            ST_DATA: if (byte_vld_i) begin
               dcnt_q <= dcnt_q + 1'b1;
               if (dcnt_q == cmd_q[LEN_W-1:0]) st_q <= ST_DONE;
            end
            ST_DONE: ;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st_q)
         ST_ADDR: tx_byte_o = (acnt_q == ACNT_LAST) ? BYTE_WAIT : BYTE_IDLE;
         ST_FLOW: tx_byte_o = go ? BYTE_START : BYTE_WAIT;
         ST_DATA: tx_byte_o = !is_rd ? BYTE_IDLE : (hw_q ? hw_byte : rd_data_i);
         default: tx_byte_o = BYTE_IDLE;
      endcase
   end

   assign rd_pop_o  = (st_q == ST_DATA) && byte_vld_i && !cs_ni && is_rd && !hw_q;
   assign wr_push_o = (st_q == ST_DATA) && byte_vld_i && !cs_ni && !is_rd;
   assign wr_data_o = rx_byte_i;

endmodule

// File: rtl/tpm_spi_engine_chk.sv
module tpm_spi_engine_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        cs_ni,
   input logic        byte_vld_i,
   input logic [7:0]  tx_byte_o,
   input logic        mb_valid_o,
   input logic [31:0] mb_data_o,
   input logic        mb_pop_i,
   input logic        irq_o,
   input logic        rd_pop_o,
   input logic        wr_push_o
);

   // R10: a deasserted select leaves the engine idle in the next cycle
   a_r10_cs_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_ni |=> (tx_byte_o == 8'hFF && !rd_pop_o && !wr_push_o));

   // R9: a held entry keeps the interrupt up until popped
   a_r9_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mb_valid_o && !mb_pop_i) |=> irq_o);

   // R9: interrupt only falls after a pop
   a_r9_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o) |-> $past(mb_pop_i));

   // R9: a full mailbox is never overwritten
   a_r9_mbox_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mb_valid_o && !mb_pop_i) |=> $stable(mb_data_o));

   // R2: entries are only posted inside a transaction
   a_r2_post_in_txn: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mb_valid_o) |-> $past(!cs_ni));

   // R8: pushes happen only in a live byte slot, never together with a pop
   a_r8_push_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_push_o |-> (byte_vld_i && !cs_ni && !rd_pop_o));

endmodule

bind tpm_spi_engine tpm_spi_engine_chk chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cs_ni      (cs_ni),
   .byte_vld_i (byte_vld_i),
   .tx_byte_o  (tx_byte_o),
   .mb_valid_o (mb_valid_o),
   .mb_data_o  (mb_data_o),
   .mb_pop_i   (mb_pop_i),
   .irq_o      (irq_o),
   .rd_pop_o   (rd_pop_o),
   .wr_push_o  (wr_push_o)
);

// File: tb/tpm_spi_engine_tb_top.sv
module tpm_spi_engine_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NLOC       = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cs_n = 1'b1;
   logic            bvld = 1'b0;
   logic [7:0]      rxb = 8'h00;
   logic [7:0]      txb;
   logic            en = 1'b0, crb = 1'b0, hwdis = 1'b0, invloc = 1'b0;
   logic [NLOC*8-1:0] acc;
   logic [31:0]     sts, idv;
   logic            mbv, mbpop = 1'b0, irq;
   logic [31:0]     mbd;
   logic            rrdy = 1'b0, rpop, wempty = 1'b1, wpush;
   logic [7:0]      rdat, wdat;

   int tests = 0, fails = 0;
   int popcnt = 0, pushcnt = 0;
   logic [7:0] wlog [0:63];
   logic [7:0] rbuf [0:63];
   logic [7:0] lastaddr_tx;
   bit done = 0;

   assign rdat = 8'hA0 + 8'(popcnt);

   always #(CLK_PERIOD/2) clk = ~clk;

   tpm_spi_engine dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .byte_vld_i(bvld),
      .rx_byte_i(rxb), .tx_byte_o(txb), .cfg_en_i(en), .cfg_crb_i(crb),
      .cfg_hwdis_i(hwdis), .cfg_invloc_i(invloc), .acc_i(acc), .sts_i(sts),
      .id_i(idv), .mb_valid_o(mbv), .mb_data_o(mbd), .mb_pop_i(mbpop),
      .irq_o(irq), .rd_ready_i(rrdy), .rd_data_i(rdat), .rd_pop_o(rpop),
      .wr_empty_i(wempty), .wr_push_o(wpush), .wr_data_o(wdat)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic spi_byte(input logic [7:0] b, output logic [7:0] got);
      @(negedge clk);
      bvld = 1'b1;
      rxb  = b;
      #1;
      got = txb;
      if (rpop) popcnt++;
      if (wpush) begin
         wlog[pushcnt] = wdat;
         pushcnt++;
      end
      @(posedge clk);
      #1 bvld = 1'b0;
   endtask

   task automatic start_txn(input logic [7:0] cmd, input logic [23:0] addr);
      logic [7:0] g;
      @(negedge clk);
      cs_n = 1'b0;
      spi_byte(cmd, g);
      spi_byte(addr[23:16], g);
      spi_byte(addr[15:8], g);
      spi_byte(addr[7:0], lastaddr_tx);
   endtask

   task automatic flow(input int maxw, output int nw, output bit started);
      logic [7:0] g;
      nw = 0;
      started = 0;
      while (!started && nw < maxw) begin
         spi_byte(8'h00, g);
         if (g == 8'h01) started = 1;
         else nw++;
      end
   endtask

   task automatic data(input int n);
      for (int i = 0; i < n; i++) spi_byte(8'h50 + 8'(i), rbuf[i]);
   endtask

   task automatic end_txn();
      @(negedge clk);
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic mb_take(input string req, input logic [31:0] exp);
      check(req, "mailbox valid", 32'(mbv), 32'd1);
      check(req, "mailbox entry", mbd, exp);
      @(negedge clk);
      mbpop = 1'b1;
      @(negedge clk);
      mbpop = 1'b0;
   endtask

   task automatic t_reset();
      check("R3", "idle reply", 32'(txb), 32'hFF);
      check("R9", "irq after reset", 32'(irq), 32'd0);
      check("R9", "mailbox after reset", 32'(mbv), 32'd0);
   endtask

   task automatic t_disabled();
      logic [7:0] g;
      logic [7:0] seq [8];
      int p0, q0;
      seq = '{8'h80, 8'hD4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      en = 1'b0; rrdy = 1'b1; wempty = 1'b1;
      p0 = popcnt; q0 = pushcnt;
      @(negedge clk) cs_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         spi_byte(seq[i], g);
         check("R1", "disabled reply", 32'(g), 32'hFF);
      end
      end_txn();
      check("R1", "disabled mailbox", 32'(mbv), 32'd0);
      check("R1", "disabled pops", popcnt - p0, 0);
      check("R1", "disabled pushes", pushcnt - q0, 0);
      en = 1'b1; rrdy = 1'b0;
   endtask

   task automatic t_hw_access();
      int nw; bit st;
      start_txn(8'h80, 24'hD40000);
      check("R3", "last address reply WAIT", 32'(lastaddr_tx), 32'h00);
      flow(4, nw, st);
      check("R4", "hw read started", 32'(st), 32'd1);
      check("R4", "hw read extra waits", nw, 0);
      data(1);
      check("R5", "access loc0", 32'(rbuf[0]), 32'h21);
      end_txn();
      check("R4", "no mailbox for hw read", 32'(mbv), 32'd0);
      start_txn(8'h80, 24'hD41000);
      flow(4, nw, st);
      data(1);
      check("R5", "access loc1", 32'(rbuf[0]), 32'hA0);
      end_txn();
   endtask

   task automatic t_hw_sts();
      int nw; bit st;
      start_txn(8'h83, 24'hD41018);
      flow(4, nw, st);
      check("R4", "status waits", nw, 0);
      data(4);
      check("R5", "status active", {rbuf[3], rbuf[2], rbuf[1], rbuf[0]}, 32'h11223344);
      end_txn();
      start_txn(8'h83, 24'hD42018);
      flow(4, nw, st);
      data(4);
      check("R5", "status inactive", {rbuf[3], rbuf[2], rbuf[1], rbuf[0]}, 32'hFFFFFFFF);
      end_txn();
      start_txn(8'h81, 24'hD40F02);
      flow(4, nw, st);
      data(2);
      check("R4", "id from byte 2", {rbuf[1], rbuf[0]}, 32'h5A6B);
      end_txn();
   endtask

   task automatic t_invloc();
      int nw; bit st;
      invloc = 1'b0;
      start_txn(8'h80, 24'hD47018);
      flow(4, nw, st);
      check("R6", "invalid loc local waits", nw, 0);
      data(1);
      check("R6", "invalid loc local data", 32'(rbuf[0]), 32'hFF);
      end_txn();
      invloc = 1'b1; rrdy = 1'b0;
      start_txn(8'h80, 24'hD47018);
      flow(3, nw, st);
      check("R6", "invalid loc to software waits", nw, 3);
      end_txn();
      mb_take("R6", 32'h80D47018);
      invloc = 1'b0;
   endtask

   task automatic t_crb();
      int nw; bit st; int p0;
      crb = 1'b1; rrdy = 1'b0;
      start_txn(8'h81, 24'hD40000);
      flow(4, nw, st);
      check("R7", "crb waits until ready", 32'(st), 32'd0);
      check("R2", "crb posted entry", mbd, 32'h81D40000);
      rrdy = 1'b1;
      flow(4, nw, st);
      check("R7", "crb start once ready", nw, 0);
      p0 = popcnt;
      data(2);
      check("R7", "crb data bytes", {rbuf[1], rbuf[0]},
            {8'hA0 + 8'(p0 + 1), 8'hA0 + 8'(p0)});
      check("R7", "crb pops", popcnt - p0, 2);
      end_txn();
      mb_take("R7", 32'h81D40000);
      crb = 1'b0;
      hwdis = 1'b1;
      start_txn(8'h80, 24'hD40000);
      flow(4, nw, st);
      check("R7", "hwdis one posting wait", nw, 1);
      p0 = popcnt;
      data(1);
      check("R7", "hwdis data", 32'(rbuf[0]), 32'(8'hA0 + 8'(p0)));
      end_txn();
      mb_take("R7", 32'h80D40000);
      hwdis = 1'b0; rrdy = 1'b0;
   endtask

   task automatic t_write();
      int nw; bit st; int q0;
      wempty = 1'b0;
      start_txn(8'h01, 24'hD40024);
      flow(3, nw, st);
      check("R8", "write waits while fifo busy", nw, 3);
      check("R2", "write entry", mbd, 32'h01D40024);
      wempty = 1'b1;
      flow(3, nw, st);
      check("R8", "write start", nw, 0);
      q0 = pushcnt;
      data(2);
      check("R8", "write pushes", pushcnt - q0, 2);
      check("R8", "write payload", {wlog[q0+1], wlog[q0]}, 32'h5150);
      end_txn();
   endtask

   task automatic t_mbox_full();
      int nw; bit st; int q0;
      start_txn(8'h02, 24'hD40028);
      flow(3, nw, st);
      check("R9", "full mailbox stalls", nw, 3);
      check("R9", "irq while held", 32'(irq), 32'd1);
      mb_take("R9", 32'h01D40024);
      flow(3, nw, st);
      check("R9", "start after pop", 32'(st), 32'd1);
      check("R9", "new entry", mbd, 32'h02D40028);
      check("R9", "irq for new entry", 32'(irq), 32'd1);
      q0 = pushcnt;
      data(3);
      check("R8", "three pushes", pushcnt - q0, 3);
      end_txn();
      mb_take("R9", 32'h02D40028);
      check("R9", "irq low after pop", 32'(irq), 32'd0);
   endtask

   task automatic t_abort();
      logic [7:0] g; int nw; bit st;
      @(negedge clk) cs_n = 1'b0;
      spi_byte(8'h01, g);
      spi_byte(8'hD4, g);
      end_txn();
      start_txn(8'h80, 24'hD40000);
      flow(4, nw, st);
      check("R10", "fresh decode after abort", nw, 0);
      data(1);
      check("R10", "data after abort", 32'(rbuf[0]), 32'h21);
      end_txn();
      check("R10", "no post from aborted frame", 32'(mbv), 32'd0);
   endtask

   task automatic t_sample();
      int nw; bit st;
      start_txn(8'h83, 24'hD41018);
      sts = 32'h99887766;
      flow(4, nw, st);
      data(4);
      check("R11", "status held in txn", {rbuf[3], rbuf[2], rbuf[1], rbuf[0]}, 32'h11223344);
      end_txn();
      start_txn(8'h83, 24'hD41018);
      flow(4, nw, st);
      data(4);
      check("R11", "status after idle", {rbuf[3], rbuf[2], rbuf[1], rbuf[0]}, 32'h99887766);
      end_txn();
   endtask

   task automatic t_len_end();
      int nw; bit st; int p0; logic [7:0] g;
      crb = 1'b1; rrdy = 1'b1;
      start_txn(8'h80, 24'hD40000);
      flow(4, nw, st);
      data(1);
      p0 = popcnt;
      spi_byte(8'h00, g);
      check("R12", "first extra byte", 32'(g), 32'hFF);
      spi_byte(8'h00, g);
      check("R12", "second extra byte", 32'(g), 32'hFF);
      check("R12", "no pop past length", popcnt - p0, 0);
      end_txn();
      mb_take("R12", 32'h80D40000);
      crb = 1'b0; rrdy = 1'b0;
   endtask

   initial begin
      acc = {8'h00, 8'h00, 8'h01, 8'hA0, 8'h21};
      sts = 32'h11223344;
      idv = 32'h5A6B7C8D;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_disabled();
      t_hw_access();
      t_hw_sts();
      t_invloc();
      t_crb();
      t_write();
      t_mbox_full();
      t_abort();
      t_sample();
      t_len_end();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule